// File: doc/BRIEF.md
# I2S audio serial transmitter

This block turns 32-bit stereo PCM words into a standard I2S serial stream. Each word holds the left sample in its upper 16 bits and the right sample in its lower 16 bits. Words come one at a time from a show-ahead sample FIFO. A divider on the system clock produces a master clock and a bit clock. On the falling edge of the internal bit clock, the block drives word select and serial data. A receiver samples them on the rising edge.

A channel mode input selects stereo, mono-left, mono-right or mute. The mode is sampled once per word, when the word is loaded, so a change made while a word is being shifted takes effect only from the next word. A start input begins streaming at the next word boundary. Clearing start ends streaming at the next word boundary. An output-enable input forces every pin to a fixed idle level, and the idle level of the bit clock follows the polarity input. If the FIFO is empty at a word boundary while start is still set, the block sends a silent word and the clocks keep running.

Top module: `i2s_tx`

## Requirements
- R1: While `en_i` is 0, the dividers and the serializer are held idle. No FIFO read occurs, `mclk_o`, `ws_o` and `sd_o` stay 0, and `bclk_o` stays at the level of `bclk_pol_i`. Dropping `en_i` during streaming stops it within a few cycles.
- R2: While `out_en_i` is 0, `mclk_o`, `ws_o` and `sd_o` are 0 and `bclk_o` equals `bclk_pol_i`. This holds even while the block is streaming.
- R3: With `bclk_pol_i` = 1 the bit clock is inverted, so data changes on rising edges of `bclk_o`. With 0, data changes on falling edges of `bclk_o`.
- R4: In stereo mode (`mode_i` = 00), the left slot carries word bits [31:16] and the right slot carries bits [15:0]. Each slot is sent MSB first, with word select low for the left slot and high for the right slot.
- R5: Serial data lags word select by one bit clock. The MSB of a slot is sent in the bit period that follows the word-select transition.
- R6: Mode encodings: 01 is mono-right (left slot is zero), 10 is mono-left (right slot is zero) and 11 is mute (both slots are zero).
- R7: A change of `mode_i` while a word is being shifted takes effect only from the next word.
- R8: Each word is taken with a single one-cycle `fifo_rd_o` pulse at a word boundary, and the data is used in that same cycle. Left-slot output starts at the first word boundary after `start_i` rises.
- R9: If the FIFO is empty at a word boundary while `start_i` is 1, an all-zero word is sent, no read is issued, and the clocks keep running.
- R10: When `start_i` is cleared, the current word finishes. After that, word select and data stay low and no further frames or reads occur.
- R11: `mclk_o` has a period of 2*`MCLK_HALF` system cycles and `bclk_o` has a period of 2*`BCLK_HALF` system cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Module enable; runs the dividers |
| out_en_i | input | 1 | Pin output enable |
| start_i | input | 1 | Start/stop streaming |
| bclk_pol_i | input | 1 | Bit-clock polarity |
| mode_i | input | 2 | Channel mode: 00 stereo, 01 mono-right, 10 mono-left, 11 mute |
| fifo_data_i | input | 32 | FIFO head word: left sample in [31:16], right sample in [15:0] |
| fifo_empty_i | input | 1 | FIFO empty |
| fifo_rd_o | output | 1 | FIFO read (pop) pulse |
| mclk_o | output | 1 | Master clock |
| bclk_o | output | 1 | Bit clock |
| ws_o | output | 1 | Word select (0 = left) |
| sd_o | output | 1 | Serial data |

## Verification
The assertions assume that the FIFO is show-ahead, so `fifo_data_i` already holds the head word in the cycle `fifo_rd_o` pulses. They also assume the FIFO pops exactly once per pulse. The bench FIFO model presents `mem[rp]` combinationally and advances `rp` only on a read. Control inputs (`mode_i`, `start_i`, `en_i`, `out_en_i`) are changed only on falling system-clock edges. Mode changes are placed well inside a word, so the word-boundary rule is exercised without a race at the load edge.

// File: rtl/i2s_tx_pkg.sv
package i2s_tx_pkg;

  typedef enum logic [1:0] {
    MODE_STEREO = 2'b00,
    MODE_MONO_R = 2'b01,
    MODE_MONO_L = 2'b10,
    MODE_MUTE   = 2'b11
  } chmode_e;

  // 1 when the given slot (0 = left, 1 = right) carries data in mode m
  function automatic logic keep_slot(chmode_e m, logic right);
    case (m)
      MODE_STEREO: keep_slot = 1'b1;
      MODE_MONO_L: keep_slot = ~right;
      MODE_MONO_R: keep_slot = right;
      default:     keep_slot = 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/i2s_tx_clkgen.sv
module i2s_tx_clkgen #(
  parameter int unsigned MCLK_HALF = 1,
  parameter int unsigned BCLK_HALF = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  output logic mclk_o,
  output logic bclk_o,
  output logic bclk_fall_o
);
  localparam int unsigned MCW = $clog2(MCLK_HALF) + 1;
  localparam int unsigned BCW = $clog2(BCLK_HALF) + 1;
  localparam logic [MCW-1:0] M_LAST = MCW'(MCLK_HALF - 1);
  localparam logic [BCW-1:0] B_LAST = BCW'(BCLK_HALF - 1);

  logic [MCW-1:0] mcnt_q;
  logic [BCW-1:0] bcnt_q;
  logic mclk_q, bclk_q, m_wrap, b_wrap;

  assign m_wrap = (mcnt_q == M_LAST);
  assign b_wrap = (bcnt_q == B_LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mcnt_q <= '0;
      mclk_q <= 1'b0;
    end else if (!en_i) begin
      mcnt_q <= '0;
      mclk_q <= 1'b0;
    end else if (m_wrap) begin
      mcnt_q <= '0;
      mclk_q <= ~mclk_q;
    end else begin
      mcnt_q <= mcnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bcnt_q <= '0;
      bclk_q <= 1'b0;
    end else if (!en_i) begin
      bcnt_q <= '0;
      bclk_q <= 1'b0;
    end else if (b_wrap) begin
      bcnt_q <= '0;
      bclk_q <= ~bclk_q;
    end else begin
      bcnt_q <= bcnt_q + 1'b1;
    end
  end

  assign mclk_o      = mclk_q;
  assign bclk_o      = bclk_q;
  assign bclk_fall_o = en_i & b_wrap & bclk_q;

  AST_BCLK_HALF_PERIOD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && b_wrap) |=> (bclk_q != $past(bclk_q))); // R11

endmodule

// File: rtl/i2s_tx_shifter.sv
module i2s_tx_shifter
  import i2s_tx_pkg::*;
#(
  parameter int unsigned SLOT_W = 16
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  en_i,
  input  logic                  tick_i,
  input  logic                  start_i,
  input  chmode_e               mode_i,
  input  logic [2*SLOT_W-1:0]   word_i,
  input  logic                  empty_i,
  output logic                  rd_o,
  output logic                  ws_o,
  output logic                  sd_o
);
  localparam int unsigned WORD_W = 2 * SLOT_W;
  localparam int unsigned IW     = $clog2(WORD_W);
  localparam logic [IW-1:0] LAST  = IW'(WORD_W - 1);
  localparam logic [IW-1:0] WS_ON = IW'(SLOT_W - 1);

  logic              run_q, ws_q, sd_q, load;
  logic [IW-1:0]     idx_q, idx_n;
  logic [WORD_W-1:0] sr_q, src, word_m;

  assign load  = tick_i && (idx_q == LAST) && start_i;
  assign rd_o  = load && !empty_i;
  assign idx_n = idx_q + 1'b1;
  assign src   = empty_i ? '0 : word_i;  // underrun sends silence
  assign word_m = {keep_slot(mode_i, 1'b0) ? src[WORD_W-1:SLOT_W] : {SLOT_W{1'b0}},
                   keep_slot(mode_i, 1'b1) ? src[SLOT_W-1:0]      : {SLOT_W{1'b0}}};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q <= 1'b0;
      idx_q <= LAST;
      sr_q  <= '0;
      sd_q  <= 1'b0;
      ws_q  <= 1'b0;
    end else if (!en_i) begin
      run_q <= 1'b0;
      idx_q <= LAST;
      sr_q  <= '0;
      sd_q  <= 1'b0;
      ws_q  <= 1'b0;
    end else if (tick_i) begin
      if (idx_q == LAST) begin
        if (start_i) begin
          run_q <= 1'b1;
          idx_q <= '0;
          sd_q  <= word_m[WORD_W-1];
          sr_q  <= {word_m[WORD_W-2:0], 1'b0};
          ws_q  <= 1'b0;
        end else begin
          run_q <= 1'b0;
          sd_q  <= 1'b0;
          ws_q  <= 1'b0;
        end
      end else begin
        idx_q <= idx_n;
        sd_q  <= sr_q[WORD_W-1];
        sr_q  <= {sr_q[WORD_W-2:0], 1'b0};
        // word select leads data by one bit
        ws_q  <= (idx_n >= WS_ON) && (idx_n != LAST);
      end
    end
  end

  assign ws_o = ws_q;
  assign sd_o = sd_q;

  AST_RD_AT_BOUNDARY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_o |=> (idx_q == '0)); // R8
  AST_WS_LEFT_FIRST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_q && idx_q < WS_ON) |-> !ws_q); // R5
  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_q |-> (!ws_q && !sd_q)); // R10
  AST_DIS_STOPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !run_q); // R1
  AST_UNDERRUN_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && load && empty_i) |=> !sd_q); // R9

endmodule

// File: rtl/i2s_tx_pingate.sv
module i2s_tx_pingate (
  input  logic oe_i,
  input  logic pol_i,
  input  logic mclk_i,
  input  logic bclk_i,
  input  logic ws_i,
  input  logic sd_i,
  output logic mclk_o,
  output logic bclk_o,
  output logic ws_o,
  output logic sd_o
);
  always_comb begin
    if (oe_i) begin
      mclk_o = mclk_i;
      bclk_o = bclk_i ^ pol_i;
      ws_o   = ws_i;
      sd_o   = sd_i;
    end else begin
      mclk_o = 1'b0;
      bclk_o = pol_i;  // idle level follows polarity
      ws_o   = 1'b0;
      sd_o   = 1'b0;
    end
  end
endmodule

// File: rtl/i2s_tx.sv
module i2s_tx
  import i2s_tx_pkg::*;
#(
  parameter int unsigned SLOT_W    = 16,
  parameter int unsigned MCLK_HALF = 1,
  parameter int unsigned BCLK_HALF = 4
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                en_i,
  input  logic                out_en_i,
  input  logic                start_i,
  input  logic                bclk_pol_i,
  input  logic [1:0]          mode_i,
  input  logic [2*SLOT_W-1:0] fifo_data_i,
  input  logic                fifo_empty_i,
  output logic                fifo_rd_o,
  output logic                mclk_o,
  output logic                bclk_o,
  output logic                ws_o,
  output logic                sd_o
);
  logic mclk_int, bclk_int, tick, ws_int, sd_int;

  i2s_tx_clkgen #(.MCLK_HALF(MCLK_HALF), .BCLK_HALF(BCLK_HALF)) u_clkgen (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .en_i        (en_i),
    .mclk_o      (mclk_int),
    .bclk_o      (bclk_int),
    .bclk_fall_o (tick)
  );

  i2s_tx_shifter #(.SLOT_W(SLOT_W)) u_shifter (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .en_i    (en_i),
    .tick_i  (tick),
    .start_i (start_i),
    .mode_i  (chmode_e'(mode_i)),
    .word_i  (fifo_data_i),
    .empty_i (fifo_empty_i),
    .rd_o    (fifo_rd_o),
    .ws_o    (ws_int),
    .sd_o    (sd_int)
  );

  i2s_tx_pingate u_pingate (
    .oe_i   (out_en_i),
    .pol_i  (bclk_pol_i),
    .mclk_i (mclk_int),
    .bclk_i (bclk_int),
    .ws_i   (ws_int),
    .sd_i   (sd_int),
    .mclk_o (mclk_o),
    .bclk_o (bclk_o),
    .ws_o   (ws_o),
    .sd_o   (sd_o)
  );

endmodule

// File: tb/sim_i2s_tx.sv
module sim_i2s_tx;
  localparam int SLOT_W = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  logic en = 1'b0, oe = 1'b0, start = 1'b0, pol = 1'b0;
  logic [1:0] mode = 2'b00;
  logic [31:0] fifo_data;
  logic fifo_empty, fifo_rd, mclk, bclk, ws, sd;

  logic [31:0] mem [0:15];
  int wp = 0, rp = 0;
  int n_chk = 0, n_err = 0;

  always #4 clk = ~clk;

  assign fifo_data  = mem[rp % 16];
  assign fifo_empty = (rp == wp);
  always @(posedge clk) if (fifo_rd) rp <= rp + 1;

  i2s_tx #(.SLOT_W(SLOT_W), .MCLK_HALF(1), .BCLK_HALF(2)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .out_en_i(oe), .start_i(start),
    .bclk_pol_i(pol), .mode_i(mode), .fifo_data_i(fifo_data),
    .fifo_empty_i(fifo_empty), .fifo_rd_o(fifo_rd), .mclk_o(mclk),
    .bclk_o(bclk), .ws_o(ws), .sd_o(sd)
  );

  // receiver: sample on rising edge of the data-sampling clock
  logic [15:0] rx_l [0:255];
  logic [15:0] rx_r [0:255];
  logic [15:0] sh = '0;
  logic b_prev = 1'b0, ws_last = 1'b0;
  int n = 0, nl = 0, base = 0;

  always @(negedge clk) begin
    logic b;
    b = bclk ^ pol;
    if (b && !b_prev) begin
      sh = {sh[14:0], sd};
      if (ws != ws_last) begin
        if (!ws_last) begin
          rx_l[n % 256] = sh;
          nl = nl + 1;
        end else begin
          rx_r[n % 256] = sh;
          n = n + 1;
        end
      end
      ws_last = ws;
    end
    b_prev = b;
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic push(input logic [31:0] w);
    mem[wp % 16] = w;
    wp = wp + 1;
  endtask

  task automatic wait_frames(input int k);
    for (int t = 0; t < 20000 && (n - base) < k; t++) @(negedge clk);
  endtask

  function automatic logic [15:0] exp_slot(logic [31:0] w, logic [1:0] m, logic right);
    if (!right) return (m == 2'b00 || m == 2'b10) ? w[31:16] : 16'h0;
    else        return (m == 2'b00 || m == 2'b01) ? w[15:0]  : 16'h0;
  endfunction

  task automatic settle_stop();
    int c;
    start = 1'b0;
    repeat (300) @(negedge clk);
    c = n;
    repeat (300) @(negedge clk);
    check("R10 no frames after stop", n, c);
    check("R10 ws low after stop", {31'd0, ws}, 32'd0);
    check("R10 sd low after stop", {31'd0, sd}, 32'd0);
  endtask

  task automatic t_reset();
    int tog = 0;
    logic bp;
    @(negedge clk);
    bp = bclk;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (bclk != bp || mclk || ws || sd || fifo_rd) tog++;
      bp = bclk;
    end
    check("R1 disabled pins quiet", tog, 0);
    check("R1 disabled bclk level", {31'd0, bclk}, {31'd0, pol});
  endtask

  task automatic t_rates();
    int mr = 0, br = 0;
    logic mp, bp;
    en = 1'b1; oe = 1'b1;
    repeat (10) @(negedge clk);
    mp = mclk; bp = bclk;
    for (int i = 0; i < 64; i++) begin
      @(negedge clk);
      if (mclk && !mp) mr++;
      if (bclk && !bp) br++;
      mp = mclk; bp = bclk;
    end
    check("R11 mclk rises in 64 cycles", mr, 32);
    check("R11 bclk rises in 64 cycles", br, 16);
  endtask

  task automatic t_stream(input logic [1:0] m, input logic p, input string req);
    logic [31:0] w [0:2];
    int r0;
    pol = p; mode = m;
    repeat (8) @(negedge clk);
    base = n; r0 = rp;
    for (int i = 0; i < 3; i++) begin
      w[i] = 32'h9A3C_5E71 + i * 32'h1357_2468 + m * 32'h0101_0101;
      push(w[i]);
    end
    start = 1'b1;
    wait_frames(3);
    for (int i = 0; i < 3; i++) begin
      check({req, " left slot"},  {16'd0, rx_l[(base + i) % 256]}, {16'd0, exp_slot(w[i], m, 1'b0)});
      check({req, " right slot"}, {16'd0, rx_r[(base + i) % 256]}, {16'd0, exp_slot(w[i], m, 1'b1)});
    end
    settle_stop();
    check("R8 one read per word", rp - r0, 3);
  endtask

  task automatic t_mode_switch();
    logic [31:0] w [0:2];
    int l0;
    pol = 1'b0; mode = 2'b00;
    repeat (8) @(negedge clk);
    base = n; l0 = nl;
    for (int i = 0; i < 3; i++) begin
      w[i] = 32'hF00D_8421 ^ (i * 32'h0F0F_3333);
      push(w[i]);
    end
    start = 1'b1;
    for (int t = 0; t < 5000 && nl == l0; t++) @(negedge clk);
    mode = 2'b11;  // mid-word: applies from next word
    wait_frames(3);
    check("R7 old word right slot kept", {16'd0, rx_r[base % 256]}, {16'd0, w[0][15:0]});
    check("R7 next word muted left", {16'd0, rx_l[(base + 1) % 256]}, 32'd0);
    check("R7 next word muted right", {16'd0, rx_r[(base + 2) % 256]}, 32'd0);
    settle_stop();
    mode = 2'b00;
  endtask

  task automatic t_underrun();
    int r0, br = 0;
    logic bp;
    base = n; r0 = rp;
    push(32'hBEEF_1234);
    start = 1'b1;
    wait_frames(3);
    check("R9 first word left", {16'd0, rx_l[base % 256]}, 32'h0000_BEEF);
    check("R9 first word right", {16'd0, rx_r[base % 256]}, 32'h0000_1234);
    check("R9 underrun left zero", {16'd0, rx_l[(base + 1) % 256]}, 32'd0);
    check("R9 underrun right zero", {16'd0, rx_r[(base + 2) % 256]}, 32'd0);
    check("R9 no read on empty", rp - r0, 1);
    bp = bclk;
    for (int i = 0; i < 32; i++) begin
      @(negedge clk);
      if (bclk && !bp) br++;
      bp = bclk;
    end
    check("R9 clocks keep running", br, 8);
    settle_stop();
  endtask

  task automatic t_gate();
    int bad = 0;
    push(32'h1111_2222); push(32'h3333_4444);
    pol = 1'b0;
    start = 1'b1;
    repeat (20) @(negedge clk);
    oe = 1'b0;
    for (int i = 0; i < 32; i++) begin
      @(negedge clk);
      if (mclk || ws || sd || bclk) bad++;
    end
    check("R2 gated pins pol=0", bad, 0);
    pol = 1'b1;
    bad = 0;
    for (int i = 0; i < 32; i++) begin
      @(negedge clk);
      if (mclk || ws || sd || !bclk) bad++;
    end
    check("R2 gated pins pol=1", bad, 0);
    start = 1'b0;
    repeat (200) @(negedge clk);
    pol = 1'b0; oe = 1'b1;
    wp = rp;
  endtask

  task automatic t_disable();
    int r;
    for (int i = 0; i < 4; i++) push(32'hC0DE_0000 + i);
    base = n;
    start = 1'b1;
    wait_frames(1);
    en = 1'b0;
    repeat (3) @(negedge clk);
    r = rp;
    check("R1 ws low after disable", {31'd0, ws}, 32'd0);
    check("R1 sd low after disable", {31'd0, sd}, 32'd0);
    check("R1 bclk idle after disable", {31'd0, bclk}, {31'd0, pol});
    repeat (100) @(negedge clk);
    check("R1 no reads while disabled", rp, r);
    start = 1'b0;
    wp = rp;
    en = 1'b1;
    repeat (20) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_rates();
    t_stream(2'b00, 1'b0, "R4 R5 stereo");
    t_stream(2'b10, 1'b0, "R6 mono-left");
    t_stream(2'b01, 1'b0, "R6 mono-right");
    t_stream(2'b11, 1'b0, "R6 mute");
    t_stream(2'b00, 1'b1, "R3 inverted bclk");
    t_mode_switch();
    t_underrun();
    t_gate();
    t_disable();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
    $finish;
  end
endmodule